// File: doc/BRIEF.md
# Hashed Ordering-Domain Reorder Unit

This block puts packets back in order after a pool of parallel processing elements has finished them in arbitrary order. When a packet arrives, its 104-bit flow key is folded down to pick one of K ordering domains. Each domain hands out its own run of sequence numbers. The packet leaves ingress tagged with a domain:sequence pair. A processing element that finishes a packet returns the tag together with a descriptor ID on the completion port. The unit sends a descriptor out only once every earlier packet of the same domain has been sent.

Order is kept inside each domain and nowhere else. Packets that share a flow always fall into the same domain, so they keep their order. A slow packet holds back only the packets that hashed into its own bucket. With one domain the unit becomes a plain oldest-first ordering stage.

Each domain tracks a window of 16 slots with a head pointer, a tail pointer, an occupancy count and a per-slot completion bit. Ingress stalls while the target domain is full. Domains whose head slot has completed are served by a round-robin arbiter into a one-entry output register. A two-state machine controls that register:
- ST_EMPTY holds nothing. On LOAD it moves to ST_FULL once any domain head is ready.
- In ST_FULL, when the consumer takes the entry, CHAIN stays in ST_FULL and reloads at once if another head is ready.
- In ST_FULL, when the consumer takes the entry, DRAIN returns to ST_EMPTY if no head is ready.
- In ST_FULL, STALL stays in ST_FULL while the consumer is not ready.

Top module: `ord_domain_reorder`

## Requirements
- R1: The domain on `tag_dom` equals the XOR-fold of `in_key`: bit b of the domain is the XOR of every key bit i with i mod 2 == b (K=4). It is shown whenever a key is presented, whether or not `in_valid` is set.
- R2: Each domain issues sequence numbers consecutively from 0 after reset. The number offered on `tag_seq` is consumed only when `in_valid && in_ready`.
- R3: A descriptor appears on the output only after its own completion and after every earlier descriptor of its domain has left. It carries the dom, seq and id given at completion.
- R4: Within a domain, output order is ascending sequence order. A missing completion in one domain does not hold back a completed head of another domain.
- R5: A domain holds at most 16 packets that are accepted but not yet moved into the output register. While the domain chosen by the key is at that limit, `in_ready` is low. Ingress to other domains stays open.
- R6: After reset, `out_valid` and `cmp_err` are 0 and `in_ready` is 1.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_dom`, `out_seq` and `out_id` hold their values.
- R8: When several domain heads are ready at once, the domain after the one granted last is served first, in increasing index with wrap. After reset, domain 0 has the highest priority.
- R9: A completion whose seq is not outstanding in its domain sets `cmp_err` high for exactly the cycle after it and changes no state. Not outstanding means never allocated, already completed or already released.
- R10: Sequence numbers wrap from 15 to 0, and ordering continues correctly across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Ingress packet present |
| in_key | input | 104 | Flow key to hash |
| in_ready | output | 1 | Target domain has a free slot |
| tag_dom | output | 2 | Domain chosen for in_key |
| tag_seq | output | 4 | Sequence number offered in that domain |
| cmp_valid | input | 1 | Completion present |
| cmp_dom | input | 2 | Completion domain |
| cmp_seq | input | 4 | Completion sequence number |
| cmp_id | input | 8 | Descriptor ID |
| out_valid | output | 1 | Output register holds a descriptor |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_dom | output | 2 | Released domain |
| out_seq | output | 4 | Released sequence number |
| out_id | output | 8 | Released descriptor ID |
| cmp_err | output | 1 | Completion for a non-outstanding slot (one cycle) |

## Verification
The bench aims at the following corner cases and the fault each one would expose:
- Completions in reverse order inside one domain. A design that releases whatever completes first would put later sequence numbers ahead of the head.
- A stalled domain next to a completed head elsewhere. A single global order would block the other domain's packet.
- A domain filled to 16 and then refilled across the wrap. A design with an off-by-one count would accept a 17th packet or restart the numbering wrongly.
- Several heads ready while the output register is held. Fixed priority, rather than rotation after the last grant, would show up in the release order.
- Duplicate and never-allocated completions. A design that does not detect them would miss `cmp_err` or emit a second descriptor.

// File: rtl/ordr_pkg.sv
package ordr_pkg;

    // Output-register control states
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_st_e;

endpackage

// File: rtl/ordr_hash.sv
module ordr_hash #(
    parameter int KEY_W = 104,
    parameter int DOM_W = 2
) (
    input  logic [KEY_W-1:0] key_i,
    output logic [DOM_W-1:0] dom_o
);

    // XOR-fold: key bit i lands on output bit (i mod DOM_W)
    for (genvar b = 0; b < DOM_W; b++) begin : g_bit
        always_comb begin
            dom_o[b] = 1'b0;
            for (int i = b; i < KEY_W; i += DOM_W) begin
                dom_o[b] = dom_o[b] ^ key_i[i];
            end
        end
    end

endmodule

// File: rtl/ordr_domain.sv
module ordr_domain #(
    parameter int WIN  = 16,
    parameter int ID_W = 8,
    localparam int SEQ_W = $clog2(WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             cmp_en_i,
    input  logic [SEQ_W-1:0] cmp_seq_i,
    input  logic [ID_W-1:0]  cmp_id_i,
    input  logic             pop_i,
    output logic [SEQ_W-1:0] tail_o,
    output logic             full_o,
    output logic             ready_o,
    output logic [SEQ_W-1:0] head_o,
    output logic [ID_W-1:0]  head_id_o,
    output logic             bad_o
);

    logic [SEQ_W-1:0] head_q, tail_q;
    logic [SEQ_W:0]   cnt_q;
    logic [WIN-1:0]   done_q;
    logic [ID_W-1:0]  id_q [WIN];
    logic [SEQ_W-1:0] offs;
    logic             live;
    logic             good;

    // Slot is outstanding when its distance from head is below occupancy
    assign offs  = cmp_seq_i - head_q;
    assign live  = {1'b0, offs} < cnt_q;
    assign bad_o = cmp_en_i && (!live || done_q[cmp_seq_i]);
    assign good  = cmp_en_i && !bad_o;

    assign tail_o    = tail_q;
    assign head_o    = head_q;
    assign head_id_o = id_q[head_q];
    assign full_o    = cnt_q[SEQ_W];
    assign ready_o   = (cnt_q != '0) && done_q[head_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            done_q <= '0;
        end else begin
            if (alloc_i) tail_q <= tail_q + 1'b1;
            if (pop_i) begin
                done_q[head_q] <= 1'b0;
                head_q         <= head_q + 1'b1;
            end
            if (good) done_q[cmp_seq_i] <= 1'b1;
            unique case ({alloc_i, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (good) id_q[cmp_seq_i] <= cmp_id_i;
    end

endmodule

// File: rtl/ordr_rr_arb.sv
module ordr_rr_arb #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic          adv_i,
    output logic [N-1:0]  gnt_o,
    output logic [IW-1:0] idx_o
);

    logic [IW-1:0] last_q;
    logic          found;

    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        found = 1'b0;
        for (int o = 1; o <= N; o++) begin
            int cand;
            cand = (int'(last_q) + o) % N;
            if (!found && req_i[cand]) begin
                found       = 1'b1;
                gnt_o[cand] = 1'b1;
                idx_o       = IW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     last_q <= IW'(N - 1);
        else if (adv_i) last_q <= idx_o;
    end

endmodule

// File: rtl/ord_domain_reorder.sv
module ord_domain_reorder
    import ordr_pkg::*;
#(
    parameter int NUM_DOM = 4,
    parameter int WIN     = 16,
    parameter int ID_W    = 8,
    parameter int KEY_W   = 104,
    localparam int DOM_W  = $clog2(NUM_DOM),
    localparam int SEQ_W  = $clog2(WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [KEY_W-1:0] in_key,
    output logic             in_ready,
    output logic [DOM_W-1:0] tag_dom,
    output logic [SEQ_W-1:0] tag_seq,
    input  logic             cmp_valid,
    input  logic [DOM_W-1:0] cmp_dom,
    input  logic [SEQ_W-1:0] cmp_seq,
    input  logic [ID_W-1:0]  cmp_id,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DOM_W-1:0] out_dom,
    output logic [SEQ_W-1:0] out_seq,
    output logic [ID_W-1:0]  out_id,
    output logic             cmp_err
);

    out_st_e st_q, st_d;

    logic [NUM_DOM-1:0] alloc_v, hit_v, pop_v, full_v, rdy_v, bad_v, gnt_v;
    logic [SEQ_W-1:0]   tail_a [NUM_DOM];
    logic [SEQ_W-1:0]   hseq_a [NUM_DOM];
    logic [ID_W-1:0]    hid_a  [NUM_DOM];
    logic [DOM_W-1:0]   gidx;
    logic               accept, any_rdy, pop;

    ordr_hash #(.KEY_W(KEY_W), .DOM_W(DOM_W)) u_hash (
        .key_i (in_key),
        .dom_o (tag_dom)
    );

    assign in_ready = !full_v[tag_dom];
    assign tag_seq  = tail_a[tag_dom];
    assign accept   = in_valid && in_ready;
    assign any_rdy  = |rdy_v;

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        assign alloc_v[d] = accept && (tag_dom == DOM_W'(d));
        assign hit_v[d]   = cmp_valid && (cmp_dom == DOM_W'(d));
        assign pop_v[d]   = pop && gnt_v[d];

        ordr_domain #(.WIN(WIN), .ID_W(ID_W)) u_dom (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (alloc_v[d]),
            .cmp_en_i  (hit_v[d]),
            .cmp_seq_i (cmp_seq),
            .cmp_id_i  (cmp_id),
            .pop_i     (pop_v[d]),
            .tail_o    (tail_a[d]),
            .full_o    (full_v[d]),
            .ready_o   (rdy_v[d]),
            .head_o    (hseq_a[d]),
            .head_id_o (hid_a[d]),
            .bad_o     (bad_v[d])
        );
    end

    ordr_rr_arb #(.N(NUM_DOM)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (rdy_v),
        .adv_i (pop),
        .gnt_o (gnt_v),
        .idx_o (gidx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    // Transitions: LOAD, CHAIN, DRAIN, STALL
    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        unique case (st_q)
            ST_EMPTY: begin
                if (any_rdy) begin
                    pop  = 1'b1;
                    st_d = ST_FULL;
                end
            end
            ST_FULL: begin
                if (out_ready) begin
                    if (any_rdy) pop  = 1'b1;
                    else         st_d = ST_EMPTY;
                end
            end
            default: st_d = ST_EMPTY;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_dom <= '0;
            out_seq <= '0;
            out_id  <= '0;
            cmp_err <= 1'b0;
        end else begin
            cmp_err <= |bad_v;
            if (pop) begin
                out_dom <= gidx;
                out_seq <= hseq_a[gidx];
                out_id  <= hid_a[gidx];
            end
        end
    end

    assign out_valid = (st_q == ST_FULL);

endmodule

// File: rtl/ordr_reorder_chk.sv
module ordr_reorder_chk #(
    parameter int NUM_DOM = 4,
    parameter int WIN     = 16,
    parameter int ID_W    = 8,
    localparam int DOM_W  = $clog2(NUM_DOM),
    localparam int SEQ_W  = $clog2(WIN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [DOM_W-1:0] tag_dom,
    input logic [SEQ_W-1:0] tag_seq,
    input logic             out_valid,
    input logic             out_ready,
    input logic [DOM_W-1:0] out_dom,
    input logic [SEQ_W-1:0] out_seq,
    input logic [ID_W-1:0]  out_id
);

    logic fire;
    assign fire = out_valid && out_ready;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_dom) && $stable(out_seq) && $stable(out_id))); // R7

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_chk
        logic             acc_d, fire_d;
        logic [SEQ_W+1:0] cnt_q;
        logic [SEQ_W-1:0] tag_exp_q, rel_exp_q;

        assign acc_d  = in_valid && in_ready && (tag_dom == DOM_W'(d));
        assign fire_d = fire && (out_dom == DOM_W'(d));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q     <= '0;
                tag_exp_q <= '0;
                rel_exp_q <= '0;
            end else begin
                if (acc_d)  tag_exp_q <= tag_exp_q + 1'b1;
                if (fire_d) rel_exp_q <= rel_exp_q + 1'b1;
                unique case ({acc_d, fire_d})
                    2'b10:   cnt_q <= cnt_q + 1'b1;
                    2'b01:   cnt_q <= cnt_q - 1'b1;
                    default: cnt_q <= cnt_q;
                endcase
            end
        end

        AST_TAG_CONSEC: assert property (@(posedge clk) disable iff (!rst_n)
            acc_d |-> (tag_seq == tag_exp_q)); // R2

        AST_REL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            fire_d |-> (out_seq == rel_exp_q)); // R4

        AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_ready && tag_dom == DOM_W'(d)) |-> (cnt_q >= (SEQ_W+2)'(WIN))); // R5

        AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_dom == DOM_W'(d)) |-> (cnt_q != '0)); // R3
    end

endmodule

bind ord_domain_reorder ordr_reorder_chk #(
    .NUM_DOM (NUM_DOM),
    .WIN     (WIN),
    .ID_W    (ID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tag_dom   (tag_dom),
    .tag_seq   (tag_seq),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_dom   (out_dom),
    .out_seq   (out_seq),
    .out_id    (out_id)
);

// File: tb/tb_ord_domain_reorder.sv
`timescale 1ns/1ps
module tb_ord_domain_reorder;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [103:0] in_key = '0;
    logic         in_ready;
    logic [1:0]   tag_dom;
    logic [3:0]   tag_seq;
    logic         cmp_valid = 1'b0;
    logic [1:0]   cmp_dom = '0;
    logic [3:0]   cmp_seq = '0;
    logic [7:0]   cmp_id = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [1:0]   out_dom;
    logic [3:0]   out_seq;
    logic [7:0]   out_id;
    logic         cmp_err;

    int n_chk = 0;
    int n_err = 0;
    int exp_tail [4];

    always #10 clk = ~clk;

    ord_domain_reorder dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_key(in_key), .in_ready(in_ready),
        .tag_dom(tag_dom), .tag_seq(tag_seq),
        .cmp_valid(cmp_valid), .cmp_dom(cmp_dom), .cmp_seq(cmp_seq), .cmp_id(cmp_id),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_dom(out_dom), .out_seq(out_seq), .out_id(out_id),
        .cmp_err(cmp_err)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic logic [1:0] fold(input logic [103:0] k);
        logic [1:0] f = 2'b00;
        for (int i = 0; i < 104; i++) f[i % 2] = f[i % 2] ^ k[i];
        return f;
    endfunction

    function automatic logic [103:0] mk_key(input int d, input int salt);
        logic [103:0] k;
        logic [1:0]   f;
        k = {8'(salt), 32'(salt * 32'h9E3779B1), 32'(~salt * 32'h85EBCA6B), 32'(salt ^ 32'hA5A50F0F)};
        f = fold(k);
        k[1:0] = k[1:0] ^ (f ^ 2'(d));
        return k;
    endfunction

    task automatic push(input int d, input int salt);
        @(negedge clk);
        in_key   = mk_key(d, salt);
        in_valid = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R5 ingress open", int'(in_ready), 1);
        chk(tag_dom == 2'(d), "R1 domain of key", int'(tag_dom), d);
        chk(tag_seq == 4'(exp_tail[d]), "R2 consecutive seq", int'(tag_seq), exp_tail[d]);
        @(negedge clk);
        in_valid = 1'b0;
        exp_tail[d] = (exp_tail[d] + 1) % 16;
    endtask

    task automatic complete(input int d, input int s, input int id, input bit exp_err);
        @(negedge clk);
        cmp_valid = 1'b1;
        cmp_dom   = 2'(d);
        cmp_seq   = 4'(s);
        cmp_id    = 8'(id);
        @(negedge clk);
        cmp_valid = 1'b0;
        chk(cmp_err == exp_err, "R9 error flag", int'(cmp_err), int'(exp_err));
    endtask

    task automatic pop_expect(input int d, input int s, input int id, input string rq);
        int w = 0;
        @(negedge clk);
        while (!out_valid && w < 30) begin
            @(negedge clk);
            w++;
        end
        chk(out_valid == 1'b1, rq, int'(out_valid), 1);
        chk(out_dom == 2'(d), rq, int'(out_dom), d);
        chk(out_seq == 4'(s), rq, int'(out_seq), s);
        chk(out_id == 8'(id), rq, int'(out_id), id);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int d = 0; d < 4; d++) exp_tail[d] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 reset state
        chk(out_valid == 1'b0, "R6 out_valid after reset", int'(out_valid), 0);
        chk(cmp_err == 1'b0, "R6 cmp_err after reset", int'(cmp_err), 0);
        chk(in_ready == 1'b1, "R6 in_ready after reset", int'(in_ready), 1);

        // R1 sweep of keys with in_valid low (no allocation)
        for (int s = 0; s < 64; s++) begin
            logic [103:0] k;
            k = {$urandom(), $urandom(), $urandom(), $urandom()};
            @(negedge clk);
            in_key = k;
            #1;
            chk(tag_dom == fold(k), "R1 fold sweep", int'(tag_dom), int'(fold(k)));
            chk(tag_seq == 4'd0, "R2 no consume without valid", int'(tag_seq), 0);
        end

        // R3/R4: reverse completions within domain 0
        for (int i = 0; i < 4; i++) push(0, 10 + i);
        complete(0, 3, 13, 1'b0);
        complete(0, 1, 11, 1'b0);
        complete(0, 2, 12, 1'b0);
        idle(3);
        chk(out_valid == 1'b0, "R3 head missing blocks domain", int'(out_valid), 0);
        complete(0, 0, 10, 1'b0);
        for (int i = 0; i < 4; i++) pop_expect(0, i, 10 + i, "R4 in-order release");

        // R4: a stalled domain 1 does not block domain 2
        push(1, 20); push(1, 21); push(2, 30);
        complete(1, 1, 21, 1'b0);
        complete(2, 0, 30, 1'b0);
        pop_expect(2, 0, 30, "R4 other domain passes");
        idle(3);
        chk(out_valid == 1'b0, "R4 domain 1 still blocked", int'(out_valid), 0);
        complete(1, 0, 20, 1'b0);
        // R7 hold while not ready
        idle(3);
        for (int c = 0; c < 5; c++) begin
            chk(out_valid == 1'b1 && out_seq == 4'd0 && out_id == 8'd20, "R7 held output", int'(out_id), 20);
            @(negedge clk);
        end
        pop_expect(1, 0, 20, "R3 domain 1 seq0");
        pop_expect(1, 1, 21, "R3 domain 1 seq1");

        // R5/R10: fill domain 3, stall, drain, wrap
        for (int i = 0; i < 16; i++) push(3, 40 + i);
        @(negedge clk);
        in_key = mk_key(3, 99);
        #1;
        chk(in_ready == 1'b0, "R5 full domain stalls", int'(in_ready), 0);
        in_key = mk_key(0, 98);
        #1;
        chk(in_ready == 1'b1, "R5 other domain open", int'(in_ready), 1);
        for (int i = 15; i >= 0; i--) complete(3, i, 100 + i, 1'b0);
        for (int i = 0; i < 16; i++) pop_expect(3, i, 100 + i, "R10 full window drain");
        chk(exp_tail[3] == 0, "R10 tail wrapped", exp_tail[3], 0);
        push(3, 60); push(3, 61);
        complete(3, 1, 201, 1'b0);
        complete(3, 0, 200, 1'b0);
        pop_expect(3, 0, 200, "R10 after wrap seq0");
        pop_expect(3, 1, 201, "R10 after wrap seq1");

        // R9: never-allocated and duplicate completions
        complete(2, 5, 0, 1'b1);
        chk(out_valid == 1'b0, "R9 bad completion no output", int'(out_valid), 0);
        @(negedge clk);
        chk(cmp_err == 1'b0, "R9 error lasts one cycle", int'(cmp_err), 0);
        push(2, 70);
        complete(2, 1, 77, 1'b0);
        idle(3);
        complete(2, 1, 78, 1'b1);
        pop_expect(2, 1, 77, "R9 original id kept");
        idle(3);
        chk(out_valid == 1'b0, "R9 no second release", int'(out_valid), 0);
        complete(0, 4, 0, 1'b1);

        // R8: round robin, two rounds
        push(0, 80); push(1, 81); push(2, 82); push(3, 83);
        complete(3, 2, 53, 1'b0);
        idle(3);
        complete(1, 2, 51, 1'b0);
        complete(2, 2, 52, 1'b0);
        complete(0, 4, 50, 1'b0);
        pop_expect(3, 2, 53, "R8 held first");
        pop_expect(0, 4, 50, "R8 after 3 comes 0");
        pop_expect(1, 2, 51, "R8 then 1");
        pop_expect(2, 2, 52, "R8 then 2");
        push(0, 84); push(2, 85); push(1, 86);
        complete(1, 3, 61, 1'b0);
        idle(3);
        complete(0, 5, 60, 1'b0);
        complete(2, 3, 62, 1'b0);
        pop_expect(1, 3, 61, "R8 held domain 1");
        pop_expect(2, 3, 62, "R8 after 1 comes 2");
        pop_expect(0, 5, 60, "R8 0 last");
        idle(3);
        chk(out_valid == 1'b0, "R3 nothing left", int'(out_valid), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule